// File: doc/BRIEF.md
# PWM Watchdog Trip Timer

This block guards a three-phase PWM output stage against a host that has stopped running. The host loads a 16-bit timeout value through two half-width writes, arms the timer, and then reloads it at intervals with a service strobe. A 10-bit prescaler divides the input clock by 1024. Each prescaler tick moves the timeout counter one step toward expiry. If the count runs out before the host services it, the block latches a fault. The fault drives the force-off line that gates every PWM output low, and it pulls the active-low trip pin low.

The fault stays latched after it is set. Servicing the timer or writing a new timeout value does not clear it. Only a reset or a fresh arming edge removes it, so a host that recovers must take that step on purpose. While the arm level is low, the prescaler and counter stand still, and no new fault can arise.

Top module: `pwm_wdog_trip`

## Requirements
- R1: After reset, trip_n is 1, pwm_off is 0 and both halves of the stored timeout value are 0.
- R2: The timeout value is {upper half, lower half}. wr_hi stores wr_data as the upper half and wr_lo stores it as the lower half. When both are pulsed in the same cycle, both halves take wr_data.
- R3: If the last reload took value N ≥ 1 at clock edge E, trip_n goes to 0 and pwm_off goes to 1 right after edge E + N·2^PRE_W, and not before.
- R4: A timeout value of 0 trips right after edge E + 2^PRE_W, which is the first prescaler tick after the reload.
- R5: A pulse on kick reloads the counter from the stored value and restarts the prescaler, so the timeout is measured again from that edge.
- R6: A pulse on wr_lo reloads the counter with the value that includes the byte just written, and it restarts the prescaler.
- R7: Once tripped, the outputs stay tripped through kick, wr_hi and wr_lo pulses and through a falling arm level.
- R8: A rising edge of arm clears the trip and reloads the counter. While arm is low, nothing counts and no trip can occur.
- R9: pwm_off is always the inverse of trip_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, which is also the prescaler source |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Enable level; its rising edge re-arms the timer |
| wr_hi | input | 1 | Strobe that stores wr_data as the upper half of the timeout |
| wr_lo | input | 1 | Strobe that stores wr_data as the lower half and reloads the counter |
| wr_data | input | CNT_W/2 | Half-width timeout data |
| kick | input | 1 | Service strobe that reloads the counter |
| trip_n | output | 1 | Active-low fault pin, latched |
| pwm_off | output | 1 | Forces all PWM outputs low while high |

## Verification
Two situations are hard to reach from the ports: a reload that lands partway through a running countdown, and a latched fault that later strobes must fail to clear. The bench uses a small configuration (4-bit counter, divide by 8). It sweeps every timeout value through an arming edge and checks the exact cycle on each side of the expected expiry. It then fires kick and lower-half writes partway through a countdown, before the count has expired. After a trip it sends every kind of strobe and a disarm, and confirms that only a fresh arming edge releases the outputs.

// File: rtl/pwm_wdog_pkg.sv
// Package: default sizing shared by the watchdog trip timer and its parts.
// Assumes the counter width is even so it splits into two equal halves.
package pwm_wdog_pkg;
    parameter int unsigned DEF_CNT_W = 16;   // timeout counter width
    parameter int unsigned DEF_PRE_W = 10;   // prescaler width, divide by 2**PRE_W
endpackage

// File: rtl/pwm_wdog_prescaler.sv
// Prescaler: free-running divider that emits one tick every 2**PRE_W cycles
// while enabled. A clear restarts it from zero and suppresses the tick in that
// cycle. Assumes clr has priority over everything else.
module pwm_wdog_prescaler #(
    parameter int unsigned PRE_W = pwm_wdog_pkg::DEF_PRE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;

    // Advance the divider while enabled; hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Tick on the last count of each period, never on a restart cycle.
    always_comb begin
        tick = en && !clr && (pre_q == PRE_MAX);
    end

    // R5: a restart leaves the divider at zero.
    a_r5_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));
endmodule

// File: rtl/pwm_wdog_value_reg.sv
// Timeout value store: two half-width registers written by separate strobes
// from a shared data bus. Presents the value as it will be after this
// cycle's writes, so a reload in the same cycle sees the new half.
module pwm_wdog_value_reg #(
    parameter int unsigned CNT_W = pwm_wdog_pkg::DEF_CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic [CNT_W-1:0]   next_val
);
    localparam int unsigned HALF_W = CNT_W / 2;

    logic [HALF_W-1:0] hi_q;
    logic [HALF_W-1:0] lo_q;

    // Capture each half on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (wr_hi) hi_q <= wr_data;
            if (wr_lo) lo_q <= wr_data;
        end
    end

    // Forward this cycle's write so reloads use the freshly written value.
    always_comb begin
        next_val = {wr_hi ? wr_data : hi_q, wr_lo ? wr_data : lo_q};
    end
endmodule

// File: rtl/pwm_wdog_counter.sv
// Timeout counter: loads on request, steps down once per prescaler tick, and
// flags expiry on the tick that finds it at one or zero. Assumes the load
// input has priority over a tick in the same cycle.
module pwm_wdog_counter #(
    parameter int unsigned CNT_W = pwm_wdog_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Reload from the stored value or step down on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q > ONE)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Expiry is the tick that finds the count exhausted.
    always_comb begin
        expire = tick && !load && (cnt_q <= ONE);
    end

    // R5: a reload takes the presented value.
    a_r5_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
    // R3: each tick above the floor moves the count down by exactly one.
    a_r3_one_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && (cnt_q > ONE)) |=> (cnt_q == $past(cnt_q) - ONE));
    // R3: without a reload the count never rises.
    a_r3_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/pwm_wdog_trip.sv
// Watchdog trip timer top: joins the value store, prescaler and counter, and
// latches the fault that drives the trip pin and the PWM force-off line.
// Assumes the host services it with kick or a lower-half write; only reset
// or a rising arm edge clears a latched fault.
module pwm_wdog_trip #(
    parameter int unsigned CNT_W = pwm_wdog_pkg::DEF_CNT_W,
    parameter int unsigned PRE_W = pwm_wdog_pkg::DEF_PRE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic               kick,
    output logic               trip_n,
    output logic               pwm_off
);
    logic             arm_q;
    logic             arm_rise;
    logic             reload;
    logic             tick;
    logic             expire;
    logic             tripped_q;
    logic [CNT_W-1:0] next_val;

    // Remember the previous arm level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm;
    end

    // Decode the events that restart the countdown.
    always_comb begin
        arm_rise = arm && !arm_q;
        reload   = kick || wr_lo || arm_rise;
    end

    pwm_wdog_value_reg #(.CNT_W(CNT_W)) u_value (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .next_val (next_val)
    );

    pwm_wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (arm),
        .clr   (reload),
        .tick  (tick)
    );

    pwm_wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (next_val),
        .tick     (tick),
        .expire   (expire)
    );

    // Latch the fault on expiry; only a rising arm edge releases it.
    always_ff @(posedge clk) begin
        if (!rst_n || arm_rise) tripped_q <= 1'b0;
        else if (expire)        tripped_q <= 1'b1;
    end

    // Drive both fault outputs from the single latch.
    always_comb begin
        trip_n  = !tripped_q;
        pwm_off = tripped_q;
    end

    // R7: a latched fault survives everything except a rising arm edge.
    a_r7_trip_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped_q && !arm_rise) |=> tripped_q);
    // R8: no fault can appear while disarmed.
    a_r8_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !tripped_q) |=> !tripped_q);
    // R8: a rising arm edge leaves the outputs released.
    a_r8_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm_rise |=> trip_n);
endmodule

// File: tb/tb_pwm_wdog_trip.sv
// Bench: small configuration (4-bit counter, divide by 8). It sweeps every
// timeout value and the reload, latch and disarm cases. Inputs change on the
// falling edge and outputs are sampled there.
module tb_pwm_wdog_trip;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int PRE_W      = 3;
    localparam int HALF_W     = CNT_W / 2;
    localparam int DIV        = 1 << PRE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm = 1'b0;
    logic              wr_hi = 1'b0;
    logic              wr_lo = 1'b0;
    logic [HALF_W-1:0] wr_data = '0;
    logic              kick = 1'b0;
    logic              trip_n;
    logic              pwm_off;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pwm_wdog_trip #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .kick    (kick),
        .trip_n  (trip_n),
        .pwm_off (pwm_off)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog on the run length.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Compare trip_n with the expected value; R9 pairs pwm_off with it.
    task automatic chk(input logic exp_trip_n, input string req);
        checks++;
        if (trip_n !== exp_trip_n) begin
            errors++;
            $display("FAIL %s: trip_n actual %b expected %b at cycle %0d", req, trip_n, exp_trip_n, cycles);
        end
        checks++;
        if (pwm_off !== !exp_trip_n) begin
            errors++;
            $display("FAIL R9: pwm_off actual %b expected %b at cycle %0d", pwm_off, !exp_trip_n, cycles);
        end
    endtask

    // Caller raised a strobe or arm at this falling edge; the next rising
    // edge is the reload edge. Expect release before and trip right after T.
    task automatic expect_trip(input int t, input string req);
        @(negedge clk);
        kick = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
        chk(1'b1, req);
        repeat (t - 1) @(negedge clk);
        chk(1'b1, req);
        @(negedge clk);
        chk(1'b0, req);
    endtask

    // Store a full timeout value with arm low.
    task automatic load_value(input int v);
        @(negedge clk);
        arm = 1'b0; wr_hi = 1'b1; wr_data = HALF_W'(v >> HALF_W);
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = HALF_W'(v);
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    initial begin
        // R1: reset state, then a stored value of zero times out in one tick.
        repeat (3) @(negedge clk);
        chk(1'b1, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b1, "R1");
        arm = 1'b1;
        expect_trip(DIV, "R1");

        // R3, R4, R2: sweep every value through an arming edge.
        for (int n = 0; n < (1 << CNT_W); n++) begin
            load_value(n);
            arm = 1'b1;
            expect_trip((n == 0 ? 1 : n) * DIV, n == 0 ? "R4" : "R3");
        end

        // R5: a kick partway through restarts the full countdown.
        load_value(3);
        arm = 1'b1;
        repeat (20) @(negedge clk);
        chk(1'b1, "R5");
        kick = 1'b1;
        expect_trip(3 * DIV, "R5");

        // R7: strobes and a falling arm do not release a latched trip.
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        repeat (10) @(negedge clk);
        chk(1'b0, "R7");
        wr_hi = 1'b1; wr_data = 2'd0;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 2'd1;
        @(negedge clk);
        wr_lo = 1'b0;
        repeat (2 * DIV) @(negedge clk);
        chk(1'b0, "R7");
        arm = 1'b0;
        repeat (5) @(negedge clk);
        chk(1'b0, "R7");

        // R8: a rising arm clears the trip and restarts with value 1.
        arm = 1'b1;
        expect_trip(DIV, "R8");

        // R8: disarmed right after the arming edge, it never trips.
        @(negedge clk);
        arm = 1'b0;
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        chk(1'b1, "R8");
        repeat (100) @(negedge clk);
        chk(1'b1, "R8");
        arm = 1'b1;
        expect_trip(DIV, "R8");

        // R6: a lower-half write partway through reloads with the new value.
        load_value(2);
        arm = 1'b1;
        repeat (10) @(negedge clk);
        chk(1'b1, "R6");
        wr_lo = 1'b1; wr_data = 2'd3;
        expect_trip(3 * DIV, "R6");

        // R2: both halves written together take the same data (value 10).
        @(negedge clk);
        arm = 1'b0; wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 2'd2;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0;
        arm = 1'b1;
        expect_trip(10 * DIV, "R2");

        // R1: reset releases a latched trip.
        rst_n = 1'b0;
        @(negedge clk);
        chk(1'b1, "R1");
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule